// File: doc/BRIEF.md
# Ingress Training-Sync and DIP-4 Error Monitor

This block sits behind the receive datapath of a SPI-4-style ingress link. It does not compute parity and does not align or deskew anything. Upstream logic gives it three per-cycle flags: a received word is present, that word completes a training pattern, and the DIP-4 check failed. From these flags it keeps two pieces of state.

The first is a 16-bit count of parity failures. The count stops at its ceiling and is emptied each time software reads it. The second is a run length of back-to-back training patterns. When the run reaches a programmable threshold, the block raises a sticky loss-of-synchronisation flag. That flag stays up until the higher-level synchronisation logic pulses a clear input.

A small register port gives access to the error count and the threshold. Reads return data one cycle after the request, together with a valid strobe.

Top module: `ingress_sync_monitor`

## Requirements
- R1: Each cycle with `dip4_err` high adds exactly one to the 16-bit error count.
- R2: The error count stops at 0xFFFF. Further errors leave it at 0xFFFF and it never wraps to zero.
- R3: A read at address 0 returns the count as it stood before the request, on `reg_rdata` in the next cycle with `reg_rvalid` high. The same read resets the count to zero.
- R4: Address 1 holds the 8-bit threshold in `reg_rdata[7:0]`, with the upper bits zero. It can be written and read back, and it is 0 after reset.
- R5: While the threshold is 0, `out_of_sync` is never raised, however long the training run.
- R6: With threshold N (1 to 255), `out_of_sync` is high in the cycle after the N-th consecutive training word is presented. Cycles with `rx_vld` low neither extend the run nor break it.
- R7: A valid word that is not a training word (`rx_vld` high, `rx_train` low) sets the run length back to zero.
- R8: If an error arrives in the same cycle as a clearing read of address 0, that error is counted into the cleared value, so the count is 1 afterwards.
- R9: Once raised, `out_of_sync` stays high until `oos_clr` is pulsed. A clear does not reset the run length. If a threshold hit and `oos_clr` occur in the same cycle, the flag stays high.
- R10: Writes to address 0 have no effect on the count. Reads of any address other than 0 and 1 return zero.
- R11: During and right after reset, `out_of_sync`, `reg_rvalid` and `reg_rdata` are low, and the error count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | A received word is present this cycle |
| rx_train | input | 1 | The present word completes a training pattern |
| dip4_err | input | 1 | DIP-4 check failure this cycle |
| oos_clr | input | 1 | Pulse that clears the sticky loss-of-sync flag |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 4 | Register address (0 count, 1 threshold) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after the request |
| reg_rvalid | output | 1 | Read data strobe |
| out_of_sync | output | 1 | Sticky loss-of-synchronisation flag |

## Verification
The bench builds the block with its default widths: a 16-bit count, an 8-bit threshold, a 16-bit data bus and a 4-bit address. With these values, real saturation of the count is reached after about 65.5 thousand error cycles. The largest threshold, 255, can be exercised end to end. The same build also covers the smallest non-zero threshold, the disabled setting, and a clear that coincides with a fresh hit.

// File: rtl/ism_pkg.sv
package ism_pkg;

  // decoded target of a register access
  typedef enum logic [1:0] {
    SEL_ERRCNT = 2'd0,
    SEL_THRESH = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/ism_reg_port.sv
module ism_reg_port
  import ism_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int THR_W    = 8,
  parameter int CNT_ADDR = 0,
  parameter int THR_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              cnt_clr,
  output logic [THR_W-1:0]  thr_val,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);

  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_ADDR);
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(THR_ADDR);

  reg_sel_e          sel;
  logic              thr_we;
  logic [THR_W-1:0]  thr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    if (reg_addr == A_CNT)      sel = SEL_ERRCNT;
    else if (reg_addr == A_THR) sel = SEL_THRESH;
    else                        sel = SEL_NONE;
  end

  // a read of the count empties it; writes there are dropped
  assign cnt_clr = reg_rd && (sel == SEL_ERRCNT);
  assign thr_we  = reg_wr && (sel == SEL_THRESH);

  function automatic logic [DATA_W-1:0] read_value(
    input reg_sel_e         s,
    input logic [CNT_W-1:0] cnt,
    input logic [THR_W-1:0] thr
  );
    case (s)
      SEL_ERRCNT: return DATA_W'(cnt);
      SEL_THRESH: return DATA_W'(thr);
      default:    return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_we) begin
      thr_q <= reg_wdata[THR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      rdata_q  <= reg_rd ? read_value(sel, cnt_val, thr_q) : '0;
    end
  end

  generate
    if (DATA_W > THR_W) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:THR_W];
    end
  endgenerate

  assign thr_val    = thr_q;
  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

endmodule

// File: rtl/ism_err_counter.sv
module ism_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_in,
  input  logic             clr_in,
  output logic [CNT_W-1:0] cnt_out,
  output logic             at_max
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // clear first, then count the current error into what remains
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             hit,
    input logic             clr
  );
    logic [CNT_W-1:0] base;
    base = clr ? '0 : cur;
    if (hit && (base != CNT_MAX)) return base + 1'b1;
    return base;
  endfunction

  assign cnt_d = next_count(cnt_q, err_in, clr_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_out = cnt_q;
  assign at_max  = (cnt_q == CNT_MAX);

endmodule

// File: rtl/ism_train_run.sv
module ism_train_run #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_vld,
  input  logic             word_train,
  input  logic [THR_W-1:0] thr,
  input  logic             oos_clr,
  output logic [THR_W-1:0] run_len,
  output logic             lost_evt,
  output logic             oos
);

  localparam logic [THR_W-1:0] RUN_MAX = '1;

  logic [THR_W-1:0] run_q;
  logic [THR_W-1:0] run_nxt;
  logic             oos_q;
  logic             train_word;
  logic             break_word;

  function automatic logic [THR_W-1:0] run_step(
    input logic [THR_W-1:0] cur,
    input logic             vld,
    input logic             trn
  );
    if (!vld)           return cur;
    if (!trn)           return '0;
    if (cur == RUN_MAX) return cur;
    return cur + 1'b1;
  endfunction

  function automatic logic reaches(
    input logic [THR_W-1:0] run,
    input logic [THR_W-1:0] limit
  );
    return (limit != '0) && (run >= limit);
  endfunction

  assign train_word = word_vld && word_train;
  assign break_word = word_vld && !word_train;
  assign run_nxt    = run_step(run_q, word_vld, word_train);
  assign lost_evt   = train_word && reaches(run_nxt, thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      oos_q <= 1'b0;
    end else begin
      run_q <= run_nxt;
      // a fresh hit outranks a clear in the same cycle
      oos_q <= lost_evt || (oos_q && !oos_clr);
    end
  end

  generate
    if (THR_W > 0) begin : g_obs
      logic unused_break;
      assign unused_break = break_word;
    end
  endgenerate

  assign run_len = run_q;
  assign oos     = oos_q;

endmodule

// File: rtl/ingress_sync_monitor.sv
module ingress_sync_monitor #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int THR_W    = 8,
  parameter int CNT_ADDR = 0,
  parameter int THR_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic              rx_train,
  input  logic              dip4_err,
  input  logic              oos_clr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              out_of_sync
);

  // named internal events, observed by the bound checker
  logic [CNT_W-1:0] err_cnt;
  logic             cnt_clr;
  logic             cnt_at_max;
  logic [THR_W-1:0] thr_val;
  logic [THR_W-1:0] run_cnt;
  logic             lost_evt;

  ism_reg_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .THR_W   (THR_W),
    .CNT_ADDR(CNT_ADDR),
    .THR_ADDR(THR_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_val   (err_cnt),
    .cnt_clr   (cnt_clr),
    .thr_val   (thr_val),
    .reg_rdata (reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  ism_err_counter #(
    .CNT_W(CNT_W)
  ) u_errcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_in (dip4_err),
    .clr_in (cnt_clr),
    .cnt_out(err_cnt),
    .at_max (cnt_at_max)
  );

  ism_train_run #(
    .THR_W(THR_W)
  ) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (rx_vld),
    .word_train(rx_train),
    .thr       (thr_val),
    .oos_clr   (oos_clr),
    .run_len   (run_cnt),
    .lost_evt  (lost_evt),
    .oos       (out_of_sync)
  );

endmodule

// File: rtl/ingress_sync_monitor_chk.sv
module ingress_sync_monitor_chk #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dip4_err,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] err_cnt,
  input logic             cnt_at_max,
  input logic [THR_W-1:0] thr_val,
  input logic             rx_vld,
  input logic [THR_W-1:0] run_cnt,
  input logic             lost_evt,
  input logic             oos_clr,
  input logic             out_of_sync,
  input logic             reg_rd,
  input logic             reg_rvalid
);

  // R1
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dip4_err && !cnt_clr && !cnt_at_max) |=> (err_cnt == $past(err_cnt) + 1'b1));

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_at_max && !cnt_clr) |=> cnt_at_max);

  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !dip4_err) |=> (err_cnt == '0));

  // R3
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R8
  clear_and_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && dip4_err) |=> (err_cnt == CNT_W'(1)));

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_val == '0) && !out_of_sync) |=> !out_of_sync);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> $stable(run_cnt));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_of_sync && !oos_clr) |=> out_of_sync);

  // R9
  hit_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> out_of_sync);

endmodule

bind ingress_sync_monitor ingress_sync_monitor_chk #(
  .CNT_W(CNT_W),
  .THR_W(THR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .dip4_err   (dip4_err),
  .cnt_clr    (cnt_clr),
  .err_cnt    (err_cnt),
  .cnt_at_max (cnt_at_max),
  .thr_val    (thr_val),
  .rx_vld     (rx_vld),
  .run_cnt    (run_cnt),
  .lost_evt   (lost_evt),
  .oos_clr    (oos_clr),
  .out_of_sync(out_of_sync),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid)
);

// File: tb/ingress_sync_monitor_tb_top.sv
`timescale 1ns/1ps
module ingress_sync_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_vld = 1'b0, rx_train = 1'b0, dip4_err = 1'b0, oos_clr = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;
  logic        out_of_sync;

  always #4 clk = ~clk;

  ingress_sync_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_train(rx_train),
    .dip4_err(dip4_err), .oos_clr(oos_clr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .out_of_sync(out_of_sync)
  );

  typedef struct { string tag; logic [15:0] val; } exp_t;
  exp_t rdq[$];
  exp_t oosq[$];

  int n_cmp = 0;
  int n_bad = 0;

  // reference state, written from the requirements
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_thr = '0;
  logic [7:0]  m_run = '0;
  logic        m_oos = 1'b0;

  task automatic compare(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes what must follow it
  task automatic step(input logic vld, input logic trn, input logic err,
                      input logic rd, input logic wr, input logic [3:0] addr,
                      input logic [15:0] wd, input logic clr, input string tag);
    logic [15:0] rexp;
    logic [7:0]  nr;
    logic        hit;
    @(negedge clk);
    rx_vld = vld; rx_train = trn; dip4_err = err; reg_rd = rd; reg_wr = wr;
    reg_addr = addr; reg_wdata = wd; oos_clr = clr;
    if (rd) begin
      rexp = (addr == 4'd0) ? m_cnt : (addr == 4'd1) ? {8'h00, m_thr} : 16'h0000;
      rdq.push_back('{tag, rexp});
    end
    if (rd && addr == 4'd0) m_cnt = err ? 16'd1 : 16'd0;
    else if (err && m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
    nr = m_run;
    if (vld) nr = trn ? ((m_run == 8'hFF) ? m_run : m_run + 8'd1) : 8'd0;
    hit = vld && trn && (m_thr != 8'd0) && (nr >= m_thr);
    m_oos = hit ? 1'b1 : (clr ? 1'b0 : m_oos);
    m_run = nr;
    if (wr && addr == 4'd1) m_thr = wd[7:0];
    oosq.push_back('{tag, {15'd0, m_oos}});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 4'd0, 16'd0, 0, tag);
  endtask
  task automatic trains(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, 4'd0, 16'd0, 0, tag);
  endtask
  task automatic dataw(input string tag);
    step(1, 0, 0, 0, 0, 4'd0, 16'd0, 0, tag);
  endtask
  task automatic errs(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 4'd0, 16'd0, 0, tag);
  endtask
  task automatic rd(input logic [3:0] a, input logic err, input string tag);
    step(0, 0, err, 1, 0, a, 16'd0, 0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [15:0] v, input string tag);
    step(0, 0, 0, 0, 1, a, v, 0, tag);
  endtask
  task automatic clr(input logic trn, input string tag);
    step(trn, trn, 0, 0, 0, 4'd0, 16'd0, 1, tag);
  endtask

  // monitor: samples after each edge and compares against the queues
  initial forever begin
    exp_t it;
    @(posedge clk);
    #2;
    if (oosq.size() > 0) begin
      it = oosq.pop_front();
      compare(it.tag, "out_of_sync", {15'd0, out_of_sync}, it.val);
    end
    if (reg_rvalid) begin
      if (rdq.size() == 0) compare("R3", "unexpected rvalid", 16'd1, 16'd0);
      else begin
        it = rdq.pop_front();
        compare(it.tag, "reg_rdata", reg_rdata, it.val);
      end
    end else if (rdq.size() > 0) begin
      it = rdq.pop_front();
      compare(it.tag, "missing rvalid", 16'd0, 16'd1);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset values at the ports
    compare("R11", "out_of_sync in reset", {15'd0, out_of_sync}, 16'd0);
    compare("R11", "rvalid in reset", {15'd0, reg_rvalid}, 16'd0);
    compare("R11", "rdata in reset", reg_rdata, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R11");
    rd(4'd0, 0, "R11");
    rd(4'd1, 0, "R4");

    // R1 / R3 count and clear on read
    errs(5, "R1");
    idle(1, "R1");
    rd(4'd0, 0, "R1");
    rd(4'd0, 0, "R3");

    // R10 writes to the count and unmapped reads
    errs(2, "R10");
    wr(4'd0, 16'h1234, "R10");
    wr(4'd6, 16'h00AA, "R10");
    rd(4'd0, 0, "R10");
    rd(4'd2, 0, "R10");
    rd(4'd15, 0, "R10");
    rd(4'd1, 0, "R10");

    // R8 error coincident with clearing read
    errs(3, "R8");
    rd(4'd0, 1, "R8");
    rd(4'd0, 0, "R8");

    // R5 threshold zero: long training run never raises the flag
    trains(300, "R5");
    dataw("R5");

    // R4 threshold write and readback
    wr(4'd1, 16'hFF03, "R4");
    rd(4'd1, 0, "R4");

    // R6 idle cycles inside the run
    trains(2, "R6");
    idle(3, "R6");
    trains(1, "R6");
    idle(2, "R9");
    clr(0, "R9");

    // R7 a data word breaks the run
    dataw("R7");
    trains(2, "R7");
    dataw("R7");
    trains(2, "R7");
    trains(1, "R7");

    // R9 sticky, clear keeps the run, hit beats clear
    idle(4, "R9");
    clr(0, "R9");
    trains(1, "R9");
    clr(1, "R9");
    idle(1, "R9");
    dataw("R9");
    clr(0, "R9");
    idle(2, "R9");

    // R6 largest threshold
    wr(4'd1, 16'd255, "R6");
    trains(254, "R6");
    idle(1, "R6");
    trains(1, "R6");
    clr(0, "R9");
    dataw("R6");

    // R6 smallest threshold
    wr(4'd1, 16'd1, "R6");
    trains(1, "R6");
    clr(0, "R9");
    dataw("R5");
    wr(4'd1, 16'd0, "R5");
    trains(4, "R5");

    // R2 saturation
    rd(4'd0, 0, "R2");
    errs(65540, "R2");
    rd(4'd0, 1, "R2");
    rd(4'd0, 0, "R2");
    rd(4'd0, 0, "R2");

    idle(3, "R11");
    if (rdq.size() != 0) compare("R3", "reads left over", 16'(rdq.size()), 16'd0);
    summary();
    $finish;
  end

endmodule